// File: doc/BRIEF.md
# Rotating Priority Resolver with Acknowledge

This block arbitrates among eight interrupt lines. It takes the pending, mask, in-service and trigger-mode registers from the surrounding controller, plus a rotation base that decides which line currently has top priority. Its job is to name the strongest unmasked pending line and raise a request only when that line outranks everything already in service. The request and its line number are combinational outputs of the inputs.

When the processor acknowledges, the block registers a snapshot of the updated state on the same clock edge. That snapshot holds the new in-service and pending masks, the new rotation base and the vector. The controller writes these values back when the update strobe pulses. With automatic end-of-interrupt enabled, the in-service bit is released within the acknowledge itself. The rotation base can then move past the served line, and an end-of-interrupt pulse reports which line was freed. An acknowledge with nothing to serve is spurious and returns line 7.

Top module: `prio_resolver`

## Requirements
- R1: Priority index p stands for line (p + base_i) mod 8; of the set bits in a mask, the one with the lowest index wins, and an empty mask gives index 8.
- R2: The pending mask is irr_i AND NOT imr_i. req_o is 1 only when the pending winner's index is strictly lower than the index of the in-service mask, and line_o then gives that winner's line number.
- R3: When sfnm_i is 1 on a master instance, bit 2 of isr_i is left out before the in-service index is formed.
- R4: On a clock edge with ack_i high and req_o high, the next cycle shows upd_o = 1 and isr_o with the served line's bit set. irr_o has that bit cleared only when lvl_i of that line is 0 (edge-triggered). All other bits are copied from the inputs.
- R5: When aeoi_i is 1, an acknowledge with req_o high leaves the served bit clear in isr_o. It also gives eoi_o = 1 for exactly one cycle, with eoi_line_o equal to the served line.
- R6: When aeoi_i and raeoi_i are both 1, an acknowledge with req_o high gives base_o = (line + 1) mod 8. In every other acknowledge, base_o = base_i.
- R7: After an acknowledge, vec_o = {vbase_i, line}, so the upper 5 bits come from vbase_i and the lower 3 bits carry the line number.
- R8: An acknowledge with req_o low is spurious. It reports line 7 in vec_o, copies isr_i, irr_i and base_i unchanged into isr_o, irr_o and base_o, and leaves eoi_o low.
- R9: After reset, and until the first acknowledge, upd_o, eoi_o, eoi_line_o, isr_o, irr_o, base_o and vec_o are all 0. upd_o and eoi_o fall back to 0 in the cycle after an acknowledge unless ack_i stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irr_i | input | 8 | Pending request register |
| imr_i | input | 8 | Mask register, 1 blocks the line |
| isr_i | input | 8 | In-service register |
| lvl_i | input | 8 | Trigger mode per line, 1 = level, 0 = edge |
| base_i | input | 3 | Line that holds priority index 0 |
| sfnm_i | input | 1 | Special fully nested mode enable |
| aeoi_i | input | 1 | Automatic end-of-interrupt enable |
| raeoi_i | input | 1 | Rotate on automatic end-of-interrupt |
| vbase_i | input | 5 | Upper bits of the vector |
| ack_i | input | 1 | Interrupt acknowledge |
| req_o | output | 1 | Interrupt request to the processor |
| line_o | output | 3 | Winning line, 7 when no request |
| upd_o | output | 1 | One-cycle strobe: registered state valid |
| isr_o | output | 8 | Updated in-service register |
| irr_o | output | 8 | Updated pending register |
| base_o | output | 3 | Updated rotation base |
| vec_o | output | 8 | Acknowledged vector |
| eoi_o | output | 1 | One-cycle end-of-interrupt pulse |
| eoi_line_o | output | 3 | Line released by eoi_o |

## Verification
Setting and clearing the in-service bit can happen on the same acknowledge edge, and so can rotating the base. This collision happens whenever automatic end-of-interrupt is on. The sweep provokes it with the rotation option turned on and off. It also uses special fully nested mode with line 2 already in service, so that the bit being freed was set before the acknowledge. Each result is judged against a bench model: isr_o must lose the served bit, base_o must land one past the line, and the end-of-interrupt pulse must name the same line as the vector.

// File: rtl/prio_resolver.sv
module prio_resolver #(
  parameter int LINES     = 8,
  parameter int CASC_LINE = 2,
  parameter bit IS_MASTER = 1'b1,
  parameter int VEC_W     = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [LINES-1:0]         irr_i,
  input  logic [LINES-1:0]         imr_i,
  input  logic [LINES-1:0]         isr_i,
  input  logic [LINES-1:0]         lvl_i,
  input  logic [$clog2(LINES)-1:0] base_i,
  input  logic                     sfnm_i,
  input  logic                     aeoi_i,
  input  logic                     raeoi_i,
  input  logic [VEC_W-$clog2(LINES)-1:0] vbase_i,
  input  logic                     ack_i,
  output logic                     req_o,
  output logic [$clog2(LINES)-1:0] line_o,
  output logic                     upd_o,
  output logic [LINES-1:0]         isr_o,
  output logic [LINES-1:0]         irr_o,
  output logic [$clog2(LINES)-1:0] base_o,
  output logic [VEC_W-1:0]         vec_o,
  output logic                     eoi_o,
  output logic [$clog2(LINES)-1:0] eoi_line_o
);
  localparam int LW = $clog2(LINES);
  localparam int IW = LW + 1;
  localparam logic [LINES-1:0] CASC_BIT = LINES'(1) << CASC_LINE;

  function automatic logic [IW-1:0] top_index(input logic [LINES-1:0] m,
                                              input logic [LW-1:0] b);
    logic [IW-1:0] r;
    r = IW'(LINES);
    for (int p = LINES - 1; p >= 0; p--)
      if (m[LW'(p) + b]) r = IW'(p);
    return r;
  endfunction

  logic [LINES-1:0] pend, svc, sel;
  logic [IW-1:0]    p_idx, s_idx;
  logic             auto_clr;

  assign pend   = irr_i & ~imr_i;
  assign svc    = (IS_MASTER && sfnm_i) ? (isr_i & ~CASC_BIT) : isr_i;
  assign p_idx  = top_index(pend, base_i);
  assign s_idx  = top_index(svc, base_i);
  assign req_o  = p_idx < s_idx;
  assign line_o = req_o ? (p_idx[LW-1:0] + base_i) : LW'(LINES - 1);
  assign sel    = req_o ? (LINES'(1) << line_o) : '0;
  assign auto_clr = req_o && aeoi_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_o      <= 1'b0;
      eoi_o      <= 1'b0;
      eoi_line_o <= '0;
      isr_o      <= '0;
      irr_o      <= '0;
      base_o     <= '0;
      vec_o      <= '0;
    end else begin
      upd_o <= ack_i;
      eoi_o <= ack_i && auto_clr;
      if (ack_i) begin
        isr_o      <= auto_clr ? (isr_i & ~sel) : (isr_i | sel);
        irr_o      <= irr_i & ~(sel & ~lvl_i);
        base_o     <= (auto_clr && raeoi_i) ? (line_o + LW'(1)) : base_i;
        vec_o      <= {vbase_i, line_o};
        eoi_line_o <= line_o;
      end
    end
  end

  assert_req_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> (irr_i[line_o] && !imr_i[line_o]));

  assert_upd_follows_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |-> $past(ack_i));

  assert_eoi_only_on_update_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_o |-> (upd_o && !isr_o[eoi_line_o]));

  assert_service_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && req_o && !aeoi_i) |=> isr_o[vec_o[LW-1:0]]);

  assert_spurious_keeps_isr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !req_o) |=> (vec_o[LW-1:0] == LW'(LINES - 1) && isr_o == $past(isr_i) && !eoi_o));

  assert_base_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !(req_o && aeoi_i && raeoi_i)) |=> (base_o == $past(base_i)));
endmodule

// File: tb/test_prio_resolver.sv
module test_prio_resolver;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] irr_i = '0, imr_i = '0, isr_i = '0, lvl_i = '0;
  logic [2:0] base_i = '0;
  logic sfnm_i = 0, aeoi_i = 0, raeoi_i = 0, ack_i = 0;
  logic [4:0] vbase_i = '0;
  logic req_o, upd_o, eoi_o;
  logic [2:0] line_o, base_o, eoi_line_o;
  logic [7:0] isr_o, irr_o, vec_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  prio_resolver i_prio_resolver (
    .clk(clk), .rst_n(rst_n), .irr_i(irr_i), .imr_i(imr_i), .isr_i(isr_i),
    .lvl_i(lvl_i), .base_i(base_i), .sfnm_i(sfnm_i), .aeoi_i(aeoi_i),
    .raeoi_i(raeoi_i), .vbase_i(vbase_i), .ack_i(ack_i), .req_o(req_o),
    .line_o(line_o), .upd_o(upd_o), .isr_o(isr_o), .irr_o(irr_o),
    .base_o(base_o), .vec_o(vec_o), .eoi_o(eoi_o), .eoi_line_o(eoi_line_o));

  function automatic int ref_idx(logic [7:0] m, logic [2:0] b);
    for (int p = 0; p < 8; p++) if (m[(p + b) % 8]) return p;
    return 8;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model(output bit rq, output logic [2:0] ln);
    int pi, si;
    logic [7:0] sv;
    sv = sfnm_i ? (isr_i & 8'hFB) : isr_i;
    pi = ref_idx(irr_i & ~imr_i, base_i);
    si = ref_idx(sv, base_i);
    rq = pi < si;
    ln = rq ? 3'((pi + base_i) % 8) : 3'd7;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit rq;
    logic [2:0] ln;
    logic [7:0] e_isr, e_irr, e_vec;
    logic [2:0] e_base;
    bit e_eoi;
    logic [7:0] pats [4] = '{8'h00, 8'h04, 8'h10, 8'h81};
    repeat (3) @(negedge clk);
    chk(upd_o == 0 && eoi_o == 0 && isr_o == 0 && irr_o == 0 && base_o == 0
        && vec_o == 0 && eoi_line_o == 0, "R9 reset", {isr_o, vec_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(upd_o == 0 && vec_o == 0, "R9 idle", vec_o, 0);

    for (int b = 0; b < 8; b++)
      for (int s = 0; s < 4; s++)
        for (int r = 0; r < 256; r++) begin
          base_i = 3'(b); isr_i = pats[s]; irr_i = 8'(r);
          imr_i = b[0] ? 8'h24 : 8'h00; sfnm_i = (s == 1) && (b < 4);
          #1;
          model(rq, ln);
          chk(req_o == rq && line_o == ln, sfnm_i ? "R3 nested" : "R1 R2 resolve",
              {req_o, line_o}, {rq, ln});
        end

    for (int i = 0; i < 512; i++) begin
      @(negedge clk);
      irr_i = 8'(i * 37); isr_i = pats[i % 4] | ((i % 7 == 0) ? 8'h04 : 8'h00);
      base_i = 3'(i); lvl_i = ~8'(i * 13); aeoi_i = i[3]; raeoi_i = i[4];
      sfnm_i = i[5]; imr_i = i[6] ? 8'h11 : 8'h00; vbase_i = 5'(i) ^ 5'h15;
      ack_i = 1'b1;
      #1;
      model(rq, ln);
      e_isr = isr_i; e_irr = irr_i; e_base = base_i; e_eoi = 0;
      if (rq) begin
        if (aeoi_i) begin e_isr[ln] = 1'b0; e_eoi = 1; end
        else e_isr[ln] = 1'b1;
        if (!lvl_i[ln]) e_irr[ln] = 1'b0;
        if (aeoi_i && raeoi_i) e_base = ln + 3'd1;
      end
      e_vec = {vbase_i, ln};
      @(negedge clk);
      ack_i = 1'b0;
      chk(upd_o == 1, "R4 strobe", upd_o, 1);
      chk(isr_o == e_isr, rq ? (aeoi_i ? "R5 auto clear" : "R4 isr set") : "R8 spurious isr",
          isr_o, e_isr);
      chk(irr_o == e_irr, rq ? "R4 irr edge clear" : "R8 spurious irr", irr_o, e_irr);
      chk(base_o == e_base, "R6 rotation", base_o, e_base);
      chk(vec_o == e_vec, rq ? "R7 vector" : "R8 vector 7", vec_o, e_vec);
      chk(eoi_o == e_eoi && (!e_eoi || eoi_line_o == ln), "R5 eoi pulse",
          {eoi_o, eoi_line_o}, {e_eoi, ln});
      @(negedge clk);
      chk(upd_o == 0 && eoi_o == 0 && isr_o == e_isr, "R9 pulse drop",
          {upd_o, eoi_o}, 0);
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule